// File: doc/BRIEF.md
# Interface Adapter Timer and Interrupt Register Block

This block is a byte-wide register file that a host processor reaches through a simple memory-mapped bus. It holds two 16-bit down-counters, a flag register and an enable register for interrupts, an auxiliary control byte, a shift data byte, a peripheral control byte and plain data and direction bytes for two ports. It drives a single active-high interrupt request.

The first counter reloads itself from a 16-bit latch when the free-running mode is selected. The second counter is a one-shot that flags only the first time it reaches zero after a start. Both counters step once per cycle on which the prescaled `tick_en` input is high. Several register accesses clear interrupt flags as a side effect. The enable register is written with a set/clear convention carried in bit 7. An external shifter reports a finished byte through `sr_done`. The shifting itself is not part of this block.

Top module: `via_timer_regs`

## Requirements
- R1: The register index is bus address bits [12:9]; the other address bits are ignored. Index 0 is port B, 1 is port A, 2 is B direction, 3 is A direction, 15 is a separate port A byte without handshake, 11 is the auxiliary control byte and 12 is the peripheral control byte. Each of these reads back the last byte written to it.
- R2: After reset every byte register, the flags and the enables read 0. The enable register reads 0x80 because bit 7 always reads 1. The first counter and its latch are 0xFFFF, the second counter is 0xFFFF, and the interrupt output is low.
- R3: A write to index 5 puts the byte into the latch high half, loads the first counter with {byte, latch low}, and clears flag bit 6. A write to index 4 or 6 changes only the latch low half. A write to index 7 changes the latch high half and clears flag bit 6, and it does not load the counter.
- R4: The first counter steps only while auxiliary bits [7:6] are 01. Each tick decrements it, and a tick at 0xFFFF reloads it from the latch, so one period is latch + 2 ticks. In any other mode the counter holds its value.
- R5: Flag bit 6 (0x40) sets on a tick that takes the first counter to 0.
- R6: A write to index 8 stores the second counter's low reload byte. A write to index 9 loads {byte, low byte} and arms the counter. The counter decrements on every tick and wraps through 0xFFFF. Flag bit 5 (0x20) sets only on the first arrival at 0 after a load.
- R7: A read of index 4 clears flag bit 6, a read of index 8 clears flag bit 5, and a read of index 10 returns the shift byte and clears flag bit 2. Reads of indices 5 and 9 return the counter high bytes and clear nothing.
- R8: A read of index 13 returns the flags in bits [6:0], with bit 7 set when any flag is both set and enabled. A write to index 13 clears every flag written as 1. A flag event in the same cycle as a clear leaves the flag set.
- R9: A write to index 14 with bit 7 = 1 sets the enables given in bits [6:0]. With bit 7 = 0 it clears the enables written as 1. A read returns the enables with bit 7 = 1.
- R10: `irq_o` is high exactly when a set flag is enabled at bit 2 or bit 6. Flag bit 5 never drives it.
- R11: A pulse on `sr_done` sets flag bit 2 (0x04).
- R12: A read in the same cycle as a tick returns the counter value from before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled counting enable |
| sr_done | input | 1 | Shift byte finished pulse from the external shifter |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address; bits [12:9] select the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Read data is combinational, so the bench samples `bus_rdata` in the access cycle itself, before the clock edge. The value seen there is the state before any side effect. Side effects of a read or write show from the next cycle on, so the bench confirms each flag clear or counter load by a later access. A counter tick in cycle n shows in a read in cycle n+1, and a flag it sets shows in `irq_o` straight after the same edge. The bench therefore samples `irq_o` one time unit after the edge that ends the cycle in which the event occurred.

// File: rtl/via_pkg.sv
package via_pkg;
  localparam int DW  = 8;
  localparam int CW  = 2 * DW;
  localparam int FW  = DW - 1;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    RI_PB     = 4'd0,  RI_PA     = 4'd1,  RI_DIRB   = 4'd2,  RI_DIRA   = 4'd3,
    RI_T1_LO  = 4'd4,  RI_T1_HI  = 4'd5,  RI_T1_LLO = 4'd6,  RI_T1_LHI = 4'd7,
    RI_T2_LO  = 4'd8,  RI_T2_HI  = 4'd9,  RI_SHIFT  = 4'd10, RI_AUX    = 4'd11,
    RI_PERIPH = 4'd12, RI_FLAGS  = 4'd13, RI_ENABLE = 4'd14, RI_PA_RAW = 4'd15
  } reg_idx_e;

  localparam int FB_SHIFT = 2;
  localparam int FB_T2    = 5;
  localparam int FB_T1    = 6;
  localparam logic [FW-1:0] IRQ_SRC = FW'((1 << FB_SHIFT) | (1 << FB_T1));
  localparam logic [1:0]    T1_FREERUN = 2'b01;

  // free-running step: 0 goes to all-ones, all-ones reloads
  function automatic logic [CW-1:0] t1_step(input logic [CW-1:0] cnt,
                                            input logic [CW-1:0] lat);
    return (cnt == '1) ? lat : cnt - 1'b1;
  endfunction

  function automatic logic [CW-1:0] t2_step(input logic [CW-1:0] cnt);
    return cnt - 1'b1;
  endfunction
endpackage

// File: rtl/via_t1.sv
module via_t1
  import via_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          cont_en,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic          reload,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] latch,
  output logic          hit
);
  logic [CW-1:0] cnt_nxt;
  logic          stepping;

  assign cnt_nxt  = t1_step(cnt, latch);
  assign stepping = tick_en & cont_en & ~reload;
  assign hit      = stepping & (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '1;
      latch <= '1;
    end else begin
      if (lo_wr) latch[DW-1:0]  <= wdata;
      if (hi_wr) latch[CW-1:DW] <= wdata;
      if (reload)        cnt <= {wdata, latch[DW-1:0]};
      else if (stepping) cnt <= cnt_nxt;
    end
  end

  // R4: wrap from all-ones takes the latch that was held before the edge
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cont_en && !reload && cnt == '1) |=> cnt == $past(latch));
  // R4: outside free-running mode the count holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_en && !reload) |=> $stable(cnt));
  // R5: a flag event means the counter shows zero next
  assert_hit_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cnt == '0);
endmodule

// File: rtl/via_t2.sv
module via_t2
  import via_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          lo_wr,
  input  logic          start,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  logic [DW-1:0] lat_lo;
  logic          armed;
  logic [CW-1:0] cnt_nxt;

  assign cnt_nxt = t2_step(cnt);
  assign hit     = armed & tick_en & ~start & (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '1;
      lat_lo <= '0;
      armed  <= 1'b0;
    end else begin
      if (lo_wr) lat_lo <= wdata;
      if (start) begin
        cnt   <= {wdata, lat_lo};
        armed <= 1'b1;
      end else if (tick_en) begin
        cnt <= cnt_nxt;
        if (hit) armed <= 1'b0;
      end
    end
  end

  // R6: one flag per load
  assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !armed);
  // R6: a start takes the written byte over the stored low byte
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == {$past(wdata), $past(lat_lo)});
endmodule

// File: rtl/via_irq.sv
module via_irq
  import via_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_vec,
  input  logic [FW-1:0] clr_vec,
  input  logic          ier_wr,
  input  logic [DW-1:0] wdata,
  output logic [FW-1:0] ifr,
  output logic [FW-1:0] ier,
  output logic          pending,
  output logic          irq
);
  assign pending = |(ifr & ier);
  assign irq     = |(ifr & ier & IRQ_SRC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifr <= '0;
      ier <= '0;
    end else begin
      ifr <= (ifr & ~clr_vec) | set_vec;
      if (ier_wr) ier <= wdata[DW-1] ? (ier | wdata[FW-1:0]) : (ier & ~wdata[FW-1:0]);
    end
  end

  // R8: an event beats a clear in the same cycle
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> (ifr & $past(set_vec)) == $past(set_vec));
  // R9: set-form write leaves those enables on
  assert_ier_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && wdata[DW-1]) |=> (ier & $past(wdata[FW-1:0])) == $past(wdata[FW-1:0]));
  // R10: the second timer flag alone never raises the request
  assert_t2_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ifr[FB_T1] && !ifr[FB_SHIFT]) |-> !irq);
endmodule

// File: rtl/via_timer_regs.sv
module via_timer_regs
  import via_pkg::*;
#(
  parameter  int IDX_LSB = 9,
  localparam int ADDR_W  = IDX_LSB + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              sr_done,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o
);
  reg_idx_e      idx;
  logic          wr, rd;
  logic          unused_addr_bits;
  logic [DW-1:0] pb_q, pa_q, dirb_q, dira_q, sr_q, aux_q, pcr_q, pa_raw_q;
  logic [CW-1:0] t1_cnt, t1_lat, t2_cnt;
  logic          t1_hit, t2_hit;
  logic [FW-1:0] set_vec, clr_vec, ifr, ier;
  logic          pending;

  assign idx = reg_idx_e'(bus_addr[ADDR_W-1:IDX_LSB]);
  assign unused_addr_bits = ^bus_addr[IDX_LSB-1:0];
  assign wr  = bus_sel & bus_wr;
  assign rd  = bus_sel & ~bus_wr;

  via_t1 u_t1 (
    .clk, .rst_n, .tick_en,
    .cont_en (aux_q[DW-1:DW-2] == T1_FREERUN),
    .lo_wr   (wr && (idx == RI_T1_LO || idx == RI_T1_LLO)),
    .hi_wr   (wr && (idx == RI_T1_HI || idx == RI_T1_LHI)),
    .reload  (wr && idx == RI_T1_HI),
    .wdata   (bus_wdata),
    .cnt     (t1_cnt),
    .latch   (t1_lat),
    .hit     (t1_hit)
  );

  via_t2 u_t2 (
    .clk, .rst_n, .tick_en,
    .lo_wr (wr && idx == RI_T2_LO),
    .start (wr && idx == RI_T2_HI),
    .wdata (bus_wdata),
    .cnt   (t2_cnt),
    .hit   (t2_hit)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FB_T1]    = t1_hit;
    set_vec[FB_T2]    = t2_hit;
    set_vec[FB_SHIFT] = sr_done;
    clr_vec           = (wr && idx == RI_FLAGS) ? bus_wdata[FW-1:0] : '0;
    if ((rd && idx == RI_T1_LO) || (wr && (idx == RI_T1_HI || idx == RI_T1_LHI)))
      clr_vec[FB_T1] = 1'b1;
    if (rd && idx == RI_T2_LO) clr_vec[FB_T2]    = 1'b1;
    if (rd && idx == RI_SHIFT) clr_vec[FB_SHIFT] = 1'b1;
  end

  via_irq u_irq (
    .clk, .rst_n,
    .set_vec, .clr_vec,
    .ier_wr  (wr && idx == RI_ENABLE),
    .wdata   (bus_wdata),
    .ifr, .ier, .pending,
    .irq     (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_q <= '0; pa_q <= '0; dirb_q <= '0; dira_q <= '0;
      sr_q <= '0; aux_q <= '0; pcr_q <= '0; pa_raw_q <= '0;
    end else if (wr) begin
      unique case (idx)
        RI_PB:     pb_q     <= bus_wdata;
        RI_PA:     pa_q     <= bus_wdata;
        RI_DIRB:   dirb_q   <= bus_wdata;
        RI_DIRA:   dira_q   <= bus_wdata;
        RI_SHIFT:  sr_q     <= bus_wdata;
        RI_AUX:    aux_q    <= bus_wdata;
        RI_PERIPH: pcr_q    <= bus_wdata;
        RI_PA_RAW: pa_raw_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (idx)
      RI_PB:     bus_rdata = pb_q;
      RI_PA:     bus_rdata = pa_q;
      RI_DIRB:   bus_rdata = dirb_q;
      RI_DIRA:   bus_rdata = dira_q;
      RI_T1_LO:  bus_rdata = t1_cnt[DW-1:0];
      RI_T1_HI:  bus_rdata = t1_cnt[CW-1:DW];
      RI_T1_LLO: bus_rdata = t1_lat[DW-1:0];
      RI_T1_LHI: bus_rdata = t1_lat[CW-1:DW];
      RI_T2_LO:  bus_rdata = t2_cnt[DW-1:0];
      RI_T2_HI:  bus_rdata = t2_cnt[CW-1:DW];
      RI_SHIFT:  bus_rdata = sr_q;
      RI_AUX:    bus_rdata = aux_q;
      RI_PERIPH: bus_rdata = pcr_q;
      RI_FLAGS:  bus_rdata = {pending, ifr};
      RI_ENABLE: bus_rdata = {1'b1, ier};
      default:   bus_rdata = pa_raw_q;
    endcase
  end

  // R7: a low-byte read of the first counter leaves its flag clear unless a new event lands
  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && idx == RI_T1_LO && !t1_hit) |=> !ifr[FB_T1]);
  // R11: a shifter pulse is visible as a flag next cycle
  assert_shift_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sr_done |=> ifr[FB_SHIFT]);
endmodule

// File: tb/test_via_timer_regs.sv
module test_via_timer_regs;
  localparam int MAX_CYC = 150000;
  localparam int NV = 31;
  // entry: {wr, rd, tick, idx[3:0], wdata[7:0], expected[7:0]}
  localparam logic [22:0] VEC [NV] = '{
    {3'b010, 4'd0,  8'h00, 8'h00},  // R2 port B cleared
    {3'b100, 4'd0,  8'hAA, 8'h00},
    {3'b010, 4'd0,  8'h00, 8'hAA},  // R1
    {3'b100, 4'd3,  8'h5C, 8'h00},
    {3'b010, 4'd3,  8'h00, 8'h5C},  // R1
    {3'b100, 4'd15, 8'h33, 8'h00},
    {3'b010, 4'd15, 8'h00, 8'h33},  // R1
    {3'b010, 4'd1,  8'h00, 8'h00},  // R1 port A apart from raw port A
    {3'b010, 4'd4,  8'h00, 8'hFF},  // R2
    {3'b010, 4'd7,  8'h00, 8'hFF},  // R2
    {3'b010, 4'd9,  8'h00, 8'hFF},  // R2
    {3'b010, 4'd8,  8'h00, 8'hFF},  // R2
    {3'b100, 4'd14, 8'hC4, 8'h00},
    {3'b010, 4'd14, 8'h00, 8'hC4},  // R9
    {3'b100, 4'd14, 8'h04, 8'h00},
    {3'b010, 4'd14, 8'h00, 8'hC0},  // R9
    {3'b100, 4'd6,  8'h03, 8'h00},
    {3'b100, 4'd5,  8'h00, 8'h00},
    {3'b010, 4'd4,  8'h00, 8'h03},  // R3
    {3'b010, 4'd5,  8'h00, 8'h00},  // R3
    {3'b100, 4'd11, 8'h40, 8'h00},
    {3'b011, 4'd4,  8'h00, 8'h03},  // R12 read with tick sees old value
    {3'b001, 4'd0,  8'h00, 8'h00},
    {3'b001, 4'd0,  8'h00, 8'h00},
    {3'b010, 4'd13, 8'h00, 8'hC0},  // R5
    {3'b010, 4'd4,  8'h00, 8'h00},  // R7
    {3'b010, 4'd13, 8'h00, 8'h00},  // R7
    {3'b001, 4'd0,  8'h00, 8'h00},
    {3'b010, 4'd5,  8'h00, 8'hFF},  // R4
    {3'b001, 4'd0,  8'h00, 8'h00},
    {3'b010, 4'd4,  8'h00, 8'h03}   // R4 period latch+2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, sr_done = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_o;
  int n_chk = 0, n_err = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  via_timer_regs i_via_timer_regs (
    .clk, .rst_n, .tick_en, .sr_done, .bus_sel, .bus_wr,
    .bus_addr, .bus_wdata, .bus_rdata, .irq_o
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic t, input logic s,
                     input logic [3:0] idx, input logic [7:0] d, output logic [7:0] got);
    @(negedge clk);
    bus_sel = w | r; bus_wr = w; tick_en = t; sr_done = s;
    bus_addr = {idx, 9'h1A5}; bus_wdata = d;
    #1 got = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0; sr_done = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] idx, input logic [7:0] d);
    logic [7:0] g;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, idx, d, g);
  endtask

  task automatic rreg(input string req, input logic [3:0] idx, input logic [7:0] exp);
    logic [7:0] g;
    cyc(1'b0, 1'b1, 1'b0, 1'b0, idx, 8'h00, g);
    check(req, g, exp);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R2 irq after reset", {7'b0, irq_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][22], VEC[i][21], VEC[i][20], 1'b0, VEC[i][19:16], VEC[i][15:8], g);
      if (VEC[i][21]) begin
        n_chk++;
        if (g !== VEC[i][7:0]) begin
          n_err++;
          $display("FAIL table row %0d (requirement in row comment) actual %02h expected %02h",
                   i, g, VEC[i][7:0]);
        end
      end
    end

    // R4: counter holds outside free-running mode
    wreg(4'd11, 8'h00);
    repeat (3) cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00, g);
    rreg("R4 hold", 4'd4, 8'h03);

    // R3: write 7 changes latch high only, no counter load
    wreg(4'd6, 8'h11);
    wreg(4'd5, 8'h22);
    wreg(4'd7, 8'h99);
    rreg("R3 latch hi", 4'd7, 8'h99);
    rreg("R3 no reload", 4'd5, 8'h22);
    rreg("R3 latch lo", 4'd6, 8'h11);

    // R6 / R10: one-shot second counter
    wreg(4'd8, 8'h02);
    wreg(4'd9, 8'h00);
    rreg("R6 load", 4'd8, 8'h02);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00, g);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00, g);
    check("R10 t2 flag no irq", {7'b0, irq_o}, 8'h00);
    wreg(4'd14, 8'hA0);
    check("R10 t2 enabled no irq", {7'b0, irq_o}, 8'h00);
    rreg("R8 pending bit", 4'd13, 8'hA0);
    rreg("R7 hi read keeps flag", 4'd9, 8'h00);
    rreg("R7 t2 lo read", 4'd8, 8'h00);
    rreg("R7 t2 flag cleared", 4'd13, 8'h00);
    @(negedge clk) tick_en = 1'b1;
    repeat (65535) @(posedge clk);
    @(negedge clk) tick_en = 1'b0;
    rreg("R6 no second flag", 4'd13, 8'h00);
    rreg("R6 wrapped count", 4'd8, 8'h01);

    // R8: event beats clear in the same cycle
    wreg(4'd6, 8'h01);
    wreg(4'd5, 8'h00);
    wreg(4'd11, 8'h40);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 4'd13, 8'h40, g);
    check("R10 t1 irq", {7'b0, irq_o}, 8'h01);
    rreg("R7 hi read", 4'd5, 8'h00);
    rreg("R8 set wins", 4'd13, 8'hC0);
    wreg(4'd11, 8'h00);
    wreg(4'd13, 8'h40);
    rreg("R8 write clear", 4'd13, 8'h00);
    check("R10 irq dropped", {7'b0, irq_o}, 8'h00);

    // R11: shifter pulse
    wreg(4'd10, 8'h5A);
    wreg(4'd14, 8'h84);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 8'h00, g);
    check("R11 irq", {7'b0, irq_o}, 8'h01);
    rreg("R11 flag", 4'd13, 8'h84);
    rreg("R7 shift read", 4'd10, 8'h5A);
    rreg("R7 shift flag cleared", 4'd13, 8'h00);
    check("R10 irq low", {7'b0, irq_o}, 8'h00);

    // R9: clear form
    wreg(4'd14, 8'h7F);
    rreg("R9 clear", 4'd14, 8'h80);

    // R2: reset again
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rreg("R2 t1 count", 4'd4, 8'hFF);
    rreg("R2 aux", 4'd11, 8'h00);
    rreg("R2 enables", 4'd14, 8'h80);
    rreg("R2 t1 latch", 4'd6, 8'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule